// File: doc/BRIEF.md
# Multi-Channel Prescaled Down-Counter Timer

This block is a memory-mapped timer with one shared prescaler and a parameterised number (one to seven) of independent down-counting subtimers. The prescaler counts down from its reload value and emits a tick each time it passes zero. Every enabled subtimer steps down by one on each tick. When a subtimer passes zero it either reloads itself from its reload register or stops, and it can raise a pending interrupt flag.

Software drives the block through a plain word-addressed register port. Writes take effect on the next clock edge. Read data is combinational from the address. The common words sit at the bottom of the map: the prescaler value at 0x00, the prescaler reload at 0x04, the configuration word at 0x08, and a word at 0x0C that reads zero. Subtimer n has its own group at 0x10 + 0x10*n, holding the counter (+0x0), the reload (+0x4), the control word (+0x8) and a word at +0xC that reads zero.

The way the pending flag is cleared is fixed at design time. Software can find out which way applies by writing a 1 to the flag and reading it back. The interrupt outputs are either one line per subtimer or a single OR of all pending flags.

Top module: `mtu_unit`

## Requirements
- R1: After reset, every counter, reload, control word and prescaler word reads 0, and every interrupt output is low.
- R2: The configuration word reports the subtimer count in bits [2:0], the interrupt number in bits [7:3] and the separate-interrupt mode in bit 8. Bit 9 is a writable freeze flag. All other bits read 0.
- R3: The prescaler value register can be written and read. When the value is 0 the prescaler emits a tick and reloads, so with reload P there is one tick every P+1 clocks.
- R4: A subtimer with enable (control bit 0) and restart (bit 1) set, and reload R, decrements once per tick. It returns to R after R+1 ticks, so the counter has a period of (P+1)*(R+1) clocks.
- R5: A control write with the load bit (bit 2) set copies the reload register into the counter on that edge. The load bit always reads 0.
- R6: On underflow with restart clear, the counter becomes all ones and the enable bit clears.
- R7: On underflow, the pending bit (bit 4) sets only when interrupt enable (bit 3) is 1.
- R8: With PEND_CLR_ONE=1, a control write with bit 4 = 1 clears the pending bit and a write with bit 4 = 0 leaves it. With PEND_CLR_ONE=0 the roles are swapped.
- R9: While the freeze flag is set, the prescaler value and all counters hold their values.
- R10: With SEP_IRQ=1, irq_o[n] follows subtimer n's pending bit. With SEP_IRQ=0, irq_o[0] is the OR of all pending bits and the other outputs stay low.
- R11: A disabled subtimer holds its counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 7 | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | NUM_SUB | Interrupt outputs |

## Verification
The following rules are checked by assertions on every cycle:
- the prescaler reloads after a tick and holds while frozen;
- a load copies the reload register into the counter;
- an underflow with interrupt enable set raises the pending bit;
- a subtimer without restart stops at all ones;
- a disabled counter never moves.

Some behaviour can only be shown by the bench's scenarios. These include:
- the end-to-end period of (P+1)*(R+1) clocks under randomly chosen reloads;
- the opposite clear polarities, seen by driving two instances with identical writes;
- the separate and shared interrupt wiring;
- the absence of a pending flag when interrupt enable is off.

// File: rtl/mtu_pkg.sv
package mtu_pkg;
  localparam int CB_EN  = 0;
  localparam int CB_RS  = 1;
  localparam int CB_LD  = 2;
  localparam int CB_IE  = 3;
  localparam int CB_IP  = 4;
  localparam int CFG_FRZ = 9;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 7;
  localparam int CTL_W  = 5;

  typedef struct packed {
    logic ip;
    logic ie;
    logic rs;
    logic en;
  } sub_ctl_t;

  function automatic logic [CTL_W-1:0] ctl_word(input sub_ctl_t c);
    return {c.ip, c.ie, 1'b0, c.rs, c.en};
  endfunction
endpackage

// File: rtl/mtu_prescaler.sv
module mtu_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             val_we,
  input  logic             rld_we,
  input  logic [PRE_W-1:0] wdata,
  output logic [PRE_W-1:0] value_o,
  output logic [PRE_W-1:0] reload_o,
  output logic             tick_o
);
  logic [PRE_W-1:0] value_q, value_d;
  logic [PRE_W-1:0] reload_q, reload_d;

  assign tick_o = !freeze && (value_q == '0);

  always_comb begin
    value_d  = value_q;
    reload_d = reload_q;
    if (rld_we) reload_d = wdata;
    if (val_we) begin
      value_d = wdata;
    end else if (!freeze) begin
      value_d = (value_q == '0) ? reload_q : value_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q  <= '0;
      reload_q <= '0;
    end else begin
      value_q  <= value_d;
      reload_q <= reload_d;
    end
  end

  assign value_o  = value_q;
  assign reload_o = reload_q;

  AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !val_we) |=> (value_q == $past(reload_q))); // R3
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !val_we) |=> $stable(value_q)); // R9
endmodule

// File: rtl/mtu_subtimer.sv
module mtu_subtimer
  import mtu_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter bit PEND_CLR_ONE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_we,
  input  logic             rld_we,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output sub_ctl_t         ctl_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d;
  sub_ctl_t         ctl_q, ctl_d;
  logic             step, uf, pend_clr;

  assign step     = tick && ctl_q.en;
  assign uf       = step && (cnt_q == '0);
  assign pend_clr = ctl_we && (wdata[CB_IP] == PEND_CLR_ONE);

  always_comb begin
    cnt_d = cnt_q;
    rld_d = rld_q;
    ctl_d = ctl_q;
    if (rld_we) rld_d = wdata;
    if (cnt_we) begin
      cnt_d = wdata;
    end else if (ctl_we && wdata[CB_LD]) begin
      cnt_d = rld_q;
    end else if (step) begin
      if (uf) cnt_d = ctl_q.rs ? rld_q : '1;
      else    cnt_d = cnt_q - 1'b1;
    end
    if (ctl_we) begin
      ctl_d.en = wdata[CB_EN];
      ctl_d.rs = wdata[CB_RS];
      ctl_d.ie = wdata[CB_IE];
    end else if (uf && !ctl_q.rs) begin
      ctl_d.en = 1'b0;
    end
    if (uf && ctl_q.ie)  ctl_d.ip = 1'b1;
    else if (pend_clr)   ctl_d.ip = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      ctl_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
      ctl_q <= ctl_d;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign ctl_o = ctl_q;

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && wdata[CB_LD] && !cnt_we) |=> (cnt_q == $past(rld_q))); // R5
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && ctl_q.ie) |=> ctl_q.ip); // R7
  AST_STOP_NORESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !ctl_q.rs && !ctl_we && !cnt_we) |=> (!ctl_q.en && (cnt_q == '1))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.en && !cnt_we && !ctl_we) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/mtu_readmux.sv
module mtu_readmux
  import mtu_pkg::*;
#(
  parameter int NUM_SUB = 3,
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 16
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [PRE_W-1:0]              pre_val,
  input  logic [PRE_W-1:0]              pre_rld,
  input  logic [BUS_W-1:0]              cfg_word,
  input  logic [NUM_SUB-1:0][CNT_W-1:0] cnt_all,
  input  logic [NUM_SUB-1:0][CNT_W-1:0] rld_all,
  input  logic [NUM_SUB-1:0][CTL_W-1:0] ctl_all,
  output logic [BUS_W-1:0]              rdata
);
  logic [2:0] grp;
  logic [1:0] wsel;

  assign grp  = addr[6:4];
  assign wsel = addr[3:2];

  always_comb begin
    rdata = '0;
    if (grp == 3'd0) begin
      case (wsel)
        2'd0:    rdata = BUS_W'(pre_val);
        2'd1:    rdata = BUS_W'(pre_rld);
        2'd2:    rdata = cfg_word;
        default: rdata = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_SUB; i++) begin
        if (int'(grp) == i + 1) begin
          case (wsel)
            2'd0:    rdata = BUS_W'(cnt_all[i]);
            2'd1:    rdata = BUS_W'(rld_all[i]);
            2'd2:    rdata = BUS_W'(ctl_all[i]);
            default: rdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mtu_unit.sv
module mtu_unit
  import mtu_pkg::*;
#(
  parameter int NUM_SUB      = 3,
  parameter int CNT_W        = 32,
  parameter int PRE_W        = 16,
  parameter int IRQ_BASE     = 9,
  parameter bit SEP_IRQ      = 1'b1,
  parameter bit PEND_CLR_ONE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [6:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_SUB-1:0] irq_o
);
  localparam logic [2:0] NSUB_FIELD = 3'(NUM_SUB);
  localparam logic [4:0] IRQ_FIELD  = 5'(IRQ_BASE);

  logic                          wr, grp_common;
  logic [2:0]                    grp;
  logic [1:0]                    wsel;
  logic                          frz_q, frz_d;
  logic                          tick;
  logic [PRE_W-1:0]              pre_val, pre_rld;
  logic [BUS_W-1:0]              cfg_word;
  logic [NUM_SUB-1:0][CNT_W-1:0] cnt_all, rld_all;
  logic [NUM_SUB-1:0][CTL_W-1:0] ctl_all;
  logic [NUM_SUB-1:0]            pend;

  assign wr         = bus_sel && bus_we;
  assign grp        = bus_addr[6:4];
  assign wsel       = bus_addr[3:2];
  assign grp_common = (grp == 3'd0);

  always_comb begin
    frz_d = frz_q;
    if (wr && grp_common && wsel == 2'd2) frz_d = bus_wdata[CFG_FRZ];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frz_q <= 1'b0;
    else        frz_q <= frz_d;
  end

  always_comb begin
    cfg_word          = '0;
    cfg_word[2:0]     = NSUB_FIELD;
    cfg_word[7:3]     = IRQ_FIELD;
    cfg_word[8]       = SEP_IRQ;
    cfg_word[CFG_FRZ] = frz_q;
  end

  mtu_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze   (frz_q),
    .val_we   (wr && grp_common && wsel == 2'd0),
    .rld_we   (wr && grp_common && wsel == 2'd1),
    .wdata    (bus_wdata[PRE_W-1:0]),
    .value_o  (pre_val),
    .reload_o (pre_rld),
    .tick_o   (tick)
  );

  for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
    logic     hit;
    sub_ctl_t ctl;
    assign hit = wr && (int'(grp) == g + 1);
    mtu_subtimer #(.CNT_W(CNT_W), .PEND_CLR_ONE(PEND_CLR_ONE)) u_sub (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .cnt_we (hit && wsel == 2'd0),
      .rld_we (hit && wsel == 2'd1),
      .ctl_we (hit && wsel == 2'd2),
      .wdata  (bus_wdata[CNT_W-1:0]),
      .cnt_o  (cnt_all[g]),
      .rld_o  (rld_all[g]),
      .ctl_o  (ctl)
    );
    assign ctl_all[g] = ctl_word(ctl);
    assign pend[g]    = ctl.ip;
  end

  if (SEP_IRQ) begin : g_irq_sep
    assign irq_o = pend;
  end else begin : g_irq_or
    always_comb begin
      irq_o    = '0;
      irq_o[0] = |pend;
    end
  end

  mtu_readmux #(.NUM_SUB(NUM_SUB), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_rd (
    .addr     (bus_addr),
    .pre_val  (pre_val),
    .pre_rld  (pre_rld),
    .cfg_word (cfg_word),
    .cnt_all  (cnt_all),
    .rld_all  (rld_all),
    .ctl_all  (ctl_all),
    .rdata    (bus_rdata)
  );

  AST_FRZ_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q |-> !tick); // R9
endmodule

// File: tb/sim_mtu_unit.sv
module sim_mtu_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd0, rd1;
  logic [2:0]  irq0, irq1;
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  mtu_unit u0 (.clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
               .bus_wdata(wdata), .bus_rdata(rd0), .irq_o(irq0));
  mtu_unit #(.SEP_IRQ(1'b0), .PEND_CLR_ONE(1'b0)) u1 (.clk(clk), .rst_n(rst_n),
               .bus_sel(sel), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
               .bus_rdata(rd1), .irq_o(irq1));

  function automatic int exp_period(input int p, input int r);
    return (p + 1) * (r + 1);
  endfunction

  function automatic logic [31:0] exp_cfg(input bit sep, input bit frz);
    return 32'(3) | (32'(9) << 3) | (32'(sep) << 8) | (32'(frz) << 9);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d0, output logic [31:0] d1);
    @(negedge clk);
    addr = a;
    #1;
    d0 = rd0; d1 = rd1;
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [31:0] a, b, c1, c2;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(7'h10, a, b); chk("R1 counter", a, 0);
    rd(7'h18, a, b); chk("R1 ctrl", a, 0);
    rd(7'h04, a, b); chk("R1 prescaler reload", a, 0);
    chk("R1 irq", {29'b0, irq0}, 0);
    // R2 configuration fields
    rd(7'h08, a, b); chk("R2 cfg sep", a, exp_cfg(1, 0)); chk("R2 cfg shared", b, exp_cfg(0, 0));

    // R5 load while disabled, load bit reads 0
    wr(7'h14, 32'd100);
    wr(7'h18, 32'h04);
    rd(7'h10, a, b); chk("R5 load copies reload", a, 100);
    rd(7'h18, a, b); chk("R5 load bit reads 0", a, 0);
    // R11 disabled holds
    repeat (20) @(negedge clk);
    rd(7'h10, a, b); chk("R11 disabled hold", a, 100);

    // R9 freeze, R3 prescaler value access
    wr(7'h04, 32'd0);
    wr(7'h18, 32'h03);
    wr(7'h08, 32'h200);
    rd(7'h08, a, b); chk("R2 freeze bit", a, exp_cfg(1, 1));
    wr(7'h00, 32'd7);
    rd(7'h00, a, b); chk("R3 prescaler value write", a, 7);
    rd(7'h10, c1, b);
    repeat (10) @(negedge clk);
    rd(7'h10, c2, b); chk("R9 counter frozen", c2, c1);
    rd(7'h00, a, b); chk("R9 prescaler frozen", a, 7);
    wr(7'h08, 32'h0);
    repeat (20) @(negedge clk);
    rd(7'h10, c2, b); chk("R4 counts after unfreeze", {31'b0, c2 < c1}, 1);

    // R6 / R7 one-shot without restart, interrupt enabled
    wr(7'h24, 32'd3);
    wr(7'h28, 32'h0D);
    repeat (10) @(negedge clk);
    rd(7'h20, a, b); chk("R6 counter all ones", a, 32'hFFFF_FFFF);
    rd(7'h28, a, b); chk("R6 R7 ctrl en clr ip set", a, 32'h18); chk("R7 ctrl shared", b, 32'h18);
    chk("R10 sep irq", {29'b0, irq0}, 3'b010);
    chk("R10 shared irq", {29'b0, irq1}, 3'b001);

    // R8 clear polarity
    wr(7'h28, 32'h08);
    rd(7'h28, a, b); chk("R8 write0 keeps (clr-one)", a, 32'h18); chk("R8 write0 clears (clr-zero)", b, 32'h08);
    chk("R10 shared irq cleared", {29'b0, irq1}, 0);
    wr(7'h28, 32'h18);
    rd(7'h28, a, b); chk("R8 write1 clears (clr-one)", a, 32'h08); chk("R8 write1 keeps clear", b, 32'h08);
    chk("R10 sep irq cleared", {29'b0, irq0}, 0);

    // R7 no pending without interrupt enable
    wr(7'h34, 32'd2);
    wr(7'h38, 32'h05);
    repeat (10) @(negedge clk);
    rd(7'h38, a, b); chk("R7 no ip when ie=0", a, 0);
    chk("R7 irq2 low", {31'b0, irq0[2]}, 0);

    // R3 R4 random periods
    for (int t = 0; t < 8; t++) begin
      int p, r, seen, last, cyc;
      logic [31:0] prev;
      p = $urandom % 4;
      r = 1 + ($urandom % 6);
      wr(7'h04, 32'(p));
      wr(7'h14, 32'(r));
      wr(7'h18, 32'h07);
      rd(7'h10, prev, b);
      seen = 0; last = 0; cyc = 0;
      while (seen < 3 && cyc < 400) begin
        @(negedge clk); #1;
        cyc++;
        if (rd0 == 32'(r) && prev != 32'(r)) begin
          if (seen > 0) chk("R3 R4 period", 32'(cyc - last), 32'(exp_period(p, r)));
          last = cyc;
          seen++;
        end
        prev = rd0;
      end
      chk("R4 period observed", 32'(seen), 3);
    end

    finish_up();
  end
endmodule